// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block keeps the pending, in-service and trigger-kind state of 256 interrupt vectors for one core. It works out the core's current priority floor from a programmable task priority and the most urgent vector the core is still servicing. Each cycle it offers the most urgent pending vector that clears that floor. When the core takes the offered vector, the block moves it from pending to in-service. When the core signals end of interrupt, the block retires the most urgent in-service vector and tells the outside world about level-triggered completions.

Requests with a vector number in the reserved range below 16 are not handed to the core. The error vector is offered in their place and a sticky error flag is set. Repeated expiries of the timer vector are counted while its pending bit is still set, so that none is lost. Each counted expiry causes one more offer after the core takes the vector. The sources of interrupts and the register bus sit outside this block.

Top module: `intr_prio_ctrl`

## Requirements
- R1: The priority floor `pprOut` is a function of `tpr` and of the class of the highest in-service vector, where a class is bits 7:4 and counts as 0 when nothing is in service. `pprOut` equals `tpr` when the `tpr` class is greater than or equal to that class. Otherwise it is that class in bits 7:4 with bits 3:0 zero. A `tprWrite` is visible on `pprOut` after one clock edge.
- R2: `offerValid`/`offerVector` are registered. They show the highest pending vector when that vector, compared as a full 8-bit number, is greater than or equal to `pprOut`. The offer is formed from the state before the edge and appears one edge after a request is accepted. No offer is formed in a cycle with `ack`, `eoi` or `tprWrite` high.
- R3: If the vector to be offered is below 16, the error vector `errVec` is offered in its place. At the same time bit 5 of `errStatus` is set and stays set, and the pending bit of `errVec` is set.
- R4: `ack` while `offerValid` is high sets the in-service bit of the offered vector and clears its pending bit. `offerValid` is low after that edge.
- R5: `eoi` clears the highest set in-service bit, and the priority floor follows. With nothing in service, `eoi` changes nothing.
- R6: If the trigger-kind bit of the vector retired by `eoi` was set, that bit clears. `eoiBcast` is then high for exactly one cycle after the edge, with `eoiBcastVector` holding the vector.
- R7: Requests are taken only with `reqMode` 0 (fixed) or 1 (lowest priority); any other code is ignored. A request for a vector that is already pending is dropped without effect. An accepted request with `reqLevel` high also sets the vector's trigger-kind bit.
- R8: A request for `timerVec` while it is already pending adds one to a saturating counter of `CNT_W` bits. Taking `timerVec` while the counter is non-zero decrements it and leaves the pending bit set, so the vector is offered again.
- R9: While `enable` is low, requests are ignored and nothing is offered.
- R10: Synchronous active-high `rst` clears all vector state, `tpr`, the counter, `errStatus` and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| enable | input | 1 | unit enabled (global and software) |
| reqValid | input | 1 | request strobe |
| reqVector | input | 8 | requested vector |
| reqLevel | input | 1 | request is level-triggered |
| reqMode | input | 3 | delivery kind, 0 fixed, 1 lowest priority |
| tprWrite | input | 1 | load task priority |
| tprData | input | 8 | new task priority |
| ack | input | 1 | core takes the offered vector |
| eoi | input | 1 | end of interrupt |
| timerVec | input | 8 | vector used by the timer |
| errVec | input | 8 | vector used for error reporting |
| offerValid | output | 1 | a vector is offered |
| offerVector | output | 8 | offered vector |
| eoiBcast | output | 1 | level completion pulse |
| eoiBcastVector | output | 8 | vector of the completion |
| errStatus | output | 8 | sticky error flags, bit 5 illegal vector |
| pprOut | output | 8 | current priority floor |

## Verification
The bench keeps 256 vectors and sets `CNT_W` to 2, so the timer counter saturates at 3 after only a handful of extra expiries. For every one of the 16 in-service classes, all 256 task priorities are swept and the floor is compared against the formula. Every legal vector from 16 to 255 is offered at the floor boundary and one step above it. The small counter puts the saturation edge and the re-offer sequence within a short run.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLASS_W = 4;
  localparam int LOW_W   = VEC_W - CLASS_W;
  localparam logic [2:0] MODE_FIXED  = 3'd0;
  localparam logic [2:0] MODE_LOWEST = 3'd1;
  localparam int ERR_ILLEGAL_BIT = 5;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic reqSet;
    vec_t reqVec;
    logic reqLevel;
    logic ackDo;
    vec_t ackVec;
    logic ackKeep;
    logic eoiDo;
    logic errRaise;
    vec_t errVec;
    logic tprLoad;
    vec_t tprVal;
  } strobe_t;
endpackage

// File: rtl/ipc_find_high.sv
module ipc_find_high #(
  parameter int WIDTH = 256,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |bits;
    idx   = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (bits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ipc_datapath.sv
module ipc_datapath
  import ipc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  input  vec_t    probeVec,
  output logic    probeIrr,
  output logic    irrFound,
  output vec_t    irrTop,
  output logic    isrFound,
  output vec_t    isrTop,
  output logic    isrTopTmr,
  output vec_t    ppr
);
  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;
  vec_t tpr;
  logic [CLASS_W-1:0] isrClass;

  ipc_find_high #(.WIDTH(NUM_VEC)) irrEnc_i (.bits(irr), .found(irrFound), .idx(irrTop));
  ipc_find_high #(.WIDTH(NUM_VEC)) isrEnc_i (.bits(isr), .found(isrFound), .idx(isrTop));

  assign probeIrr  = irr[probeVec];
  assign isrTopTmr = tmr[isrTop];

  always_comb begin
    isrClass = isrFound ? isrTop[VEC_W-1 -: CLASS_W] : '0;
    if (tpr[VEC_W-1 -: CLASS_W] >= isrClass) ppr = tpr;
    else ppr = {isrClass, {LOW_W{1'b0}}};
  end

  always_comb begin
    irrNext = irr;
    isrNext = isr;
    tmrNext = tmr;
    if (stb.eoiDo) begin
      isrNext[isrTop] = 1'b0;
      tmrNext[isrTop] = 1'b0;
    end
    if (stb.ackDo) begin
      isrNext[stb.ackVec] = 1'b1;
      if (!stb.ackKeep) irrNext[stb.ackVec] = 1'b0;
    end
    if (stb.reqSet) begin
      irrNext[stb.reqVec] = 1'b1;
      if (stb.reqLevel) tmrNext[stb.reqVec] = 1'b1;
    end
    if (stb.errRaise) irrNext[stb.errVec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
      tpr <= '0;
    end else begin
      irr <= irrNext;
      isr <= isrNext;
      tmr <= tmrNext;
      if (stb.tprLoad) tpr <= stb.tprVal;
    end
  end
endmodule

// File: rtl/ipc_control.sv
module ipc_control
  import ipc_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LOW_LIMIT = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  logic    reqValid,
  input  vec_t    reqVector,
  input  logic    reqLevel,
  input  logic [2:0] reqMode,
  input  logic    tprWrite,
  input  vec_t    tprData,
  input  logic    ack,
  input  logic    eoi,
  input  vec_t    timerVec,
  input  vec_t    errVec,
  input  logic    probeIrr,
  input  logic    irrFound,
  input  vec_t    irrTop,
  input  logic    isrFound,
  input  vec_t    isrTop,
  input  logic    isrTopTmr,
  input  vec_t    ppr,
  output strobe_t stb,
  output logic    offerValid,
  output vec_t    offerVector,
  output logic    eoiBcast,
  output vec_t    eoiBcastVector,
  output logic [7:0] errStatus
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] timerCnt;
  logic accept, timerBump, ackTake, ackTimer, eligible, lowVec;

  always_comb begin
    accept    = reqValid && enable && (reqMode == MODE_FIXED || reqMode == MODE_LOWEST);
    timerBump = accept && probeIrr && (reqVector == timerVec);
    ackTake   = ack && offerValid;
    ackTimer  = ackTake && (offerVector == timerVec);
    eligible  = enable && irrFound && (irrTop >= ppr) && !ack && !eoi && !tprWrite;
    lowVec    = int'(irrTop) < LOW_LIMIT;

    stb          = '0;
    stb.reqSet   = accept && !probeIrr;
    stb.reqVec   = reqVector;
    stb.reqLevel = reqLevel;
    stb.ackDo    = ackTake;
    stb.ackVec   = offerVector;
    stb.ackKeep  = ackTimer && (timerCnt != '0);
    stb.eoiDo    = eoi && isrFound;
    stb.errRaise = eligible && lowVec;
    stb.errVec   = errVec;
    stb.tprLoad  = tprWrite;
    stb.tprVal   = tprData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offerValid     <= 1'b0;
      offerVector    <= '0;
      eoiBcast       <= 1'b0;
      eoiBcastVector <= '0;
      errStatus      <= '0;
      timerCnt       <= '0;
    end else begin
      offerValid  <= eligible;
      offerVector <= lowVec ? errVec : irrTop;
      eoiBcast    <= stb.eoiDo && isrTopTmr;
      if (stb.eoiDo && isrTopTmr) eoiBcastVector <= isrTop;
      if (stb.errRaise) errStatus[ERR_ILLEGAL_BIT] <= 1'b1;
      if (timerBump && !ackTimer && timerCnt != CNT_MAX) timerCnt <= timerCnt + 1'b1;
      else if (ackTimer && !timerBump && timerCnt != '0) timerCnt <= timerCnt - 1'b1;
    end
  end
endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl
  import ipc_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LOW_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       reqValid,
  input  logic [7:0] reqVector,
  input  logic       reqLevel,
  input  logic [2:0] reqMode,
  input  logic       tprWrite,
  input  logic [7:0] tprData,
  input  logic       ack,
  input  logic       eoi,
  input  logic [7:0] timerVec,
  input  logic [7:0] errVec,
  output logic       offerValid,
  output logic [7:0] offerVector,
  output logic       eoiBcast,
  output logic [7:0] eoiBcastVector,
  output logic [7:0] errStatus,
  output logic [7:0] pprOut
);
  strobe_t stb;
  logic probeIrr, irrFound, isrFound, isrTopTmr;
  vec_t irrTop, isrTop, ppr;

  ipc_datapath dp_i (
    .clk(clk), .rst(rst), .stb(stb), .probeVec(reqVector), .probeIrr(probeIrr),
    .irrFound(irrFound), .irrTop(irrTop), .isrFound(isrFound), .isrTop(isrTop),
    .isrTopTmr(isrTopTmr), .ppr(ppr)
  );

  ipc_control #(.CNT_W(CNT_W), .LOW_LIMIT(LOW_LIMIT)) ctl_i (
    .clk(clk), .rst(rst), .enable(enable), .reqValid(reqValid), .reqVector(reqVector),
    .reqLevel(reqLevel), .reqMode(reqMode), .tprWrite(tprWrite), .tprData(tprData),
    .ack(ack), .eoi(eoi), .timerVec(timerVec), .errVec(errVec), .probeIrr(probeIrr),
    .irrFound(irrFound), .irrTop(irrTop), .isrFound(isrFound), .isrTop(isrTop),
    .isrTopTmr(isrTopTmr), .ppr(ppr), .stb(stb), .offerValid(offerValid),
    .offerVector(offerVector), .eoiBcast(eoiBcast), .eoiBcastVector(eoiBcastVector),
    .errStatus(errStatus)
  );

  assign pprOut = ppr;
endmodule

// File: rtl/intr_prio_ctrl_chk.sv
module intr_prio_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       ack,
  input logic       eoi,
  input logic [7:0] errVec,
  input logic       offerValid,
  input logic [7:0] offerVector,
  input logic       eoiBcast,
  input logic [7:0] errStatus,
  input logic [7:0] pprOut
);
  p_offer_meets_ppr_r2: assert property (@(posedge clk) disable iff (rst)
    offerValid |-> (offerVector >= $past(pprOut) || offerVector == $past(errVec)));

  p_ack_withdraws_r4: assert property (@(posedge clk) disable iff (rst)
    ack |=> !offerValid);

  p_bcast_needs_eoi_r6: assert property (@(posedge clk) disable iff (rst)
    eoiBcast |-> $past(eoi));

  p_disabled_silent_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> !offerValid);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    $past(errStatus[5]) |-> errStatus[5]);
endmodule

bind intr_prio_ctrl intr_prio_ctrl_chk chk_i (.*);

// File: tb/intr_prio_ctrl_tb_top.sv
module intr_prio_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic reqValid = 1'b0;
  logic [7:0] reqVector = '0;
  logic reqLevel = 1'b0;
  logic [2:0] reqMode = '0;
  logic tprWrite = 1'b0;
  logic [7:0] tprData = '0;
  logic ack = 1'b0;
  logic eoi = 1'b0;
  logic [7:0] timerVec = 8'h90;
  logic [7:0] errVec = 8'hFE;
  logic offerValid, eoiBcast;
  logic [7:0] offerVector, eoiBcastVector, errStatus, pprOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  intr_prio_ctrl #(.CNT_W(2), .LOW_LIMIT(16)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .reqValid(reqValid), .reqVector(reqVector),
    .reqLevel(reqLevel), .reqMode(reqMode), .tprWrite(tprWrite), .tprData(tprData),
    .ack(ack), .eoi(eoi), .timerVec(timerVec), .errVec(errVec), .offerValid(offerValid),
    .offerVector(offerVector), .eoiBcast(eoiBcast), .eoiBcastVector(eoiBcastVector),
    .errStatus(errStatus), .pprOut(pprOut)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic raise(input int v, input bit lvl = 1'b0, input int mode = 0);
    reqValid = 1'b1; reqVector = 8'(v); reqLevel = lvl; reqMode = 3'(mode);
    step();
    reqValid = 1'b0; reqLevel = 1'b0; reqMode = '0;
  endtask

  task automatic doAck();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic doEoi();
    eoi = 1'b1; step(); eoi = 1'b0;
  endtask

  task automatic writeTpr(input int v);
    tprWrite = 1'b1; tprData = 8'(v); step(); tprWrite = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    step(5);
    rst = 1'b0;
    // R10: reset state
    checkEq("R10 offerValid", int'(offerValid), 0);
    checkEq("R10 ppr", int'(pprOut), 0);
    checkEq("R10 errStatus", int'(errStatus), 0);
    checkEq("R10 eoiBcast", int'(eoiBcast), 0);
    step();
    checkEq("R10 no offer after reset", int'(offerValid), 0);

    // R1: floor sweep over every in-service class and every task priority
    for (int c = 0; c < 16; c++) begin
      if (c > 0) begin
        writeTpr(0);
        raise(c * 16 + 2);
        step();
        checkEq("R2 offer valid", int'(offerValid), 1);
        checkEq("R2 offer vector", int'(offerVector), c * 16 + 2);
        doAck();
        checkEq("R4 withdrawn", int'(offerValid), 0);
      end
      for (int t = 0; t < 256; t++) begin
        writeTpr(t);
        checkEq("R1 ppr", int'(pprOut), ((t >> 4) >= c) ? t : (c << 4));
      end
      if (c > 0) begin
        doEoi();
        checkEq("R6 edge no bcast", int'(eoiBcast), 0);
        checkEq("R5 ppr after eoi", int'(pprOut), 255);
      end
    end
    writeTpr(0);

    // R2 / R4: each legal vector at its boundary
    for (int v = 16; v < 256; v++) begin
      raise(v);
      writeTpr(v);
      step();
      checkEq("R2 equal floor offered", int'(offerValid), 1);
      if (v < 255) begin
        writeTpr(v + 1);
        step();
        checkEq("R2 above floor hidden", int'(offerValid), 0);
      end
      writeTpr(0);
      step();
      checkEq("R2 vector", int'(offerVector), v);
      doAck();
      checkEq("R4 ppr is class", int'(pprOut), v & 8'hF0);
      step();
      checkEq("R4 no re-offer", int'(offerValid), 0);
      doEoi();
      checkEq("R5 ppr cleared", int'(pprOut), 0);
    end

    // R6: level completion pulse
    raise(8'h40, 1'b1);
    step();
    doAck();
    doEoi();
    checkEq("R6 bcast", int'(eoiBcast), 1);
    checkEq("R6 bcast vector", int'(eoiBcastVector), 8'h40);
    step();
    checkEq("R6 one cycle", int'(eoiBcast), 0);
    raise(8'h40);
    step();
    doAck();
    doEoi();
    checkEq("R6 trigger bit cleared", int'(eoiBcast), 0);

    // R7: duplicate dropped, trigger bit untouched
    raise(8'h50);
    raise(8'h50, 1'b1);
    step();
    checkEq("R7 dup vector", int'(offerVector), 8'h50);
    doAck();
    step();
    checkEq("R7 single entry", int'(offerValid), 0);
    doEoi();
    checkEq("R7 dup level ignored", int'(eoiBcast), 0);

    // R7: delivery kinds
    raise(8'h60, 1'b0, 4);
    step();
    checkEq("R7 mode 4 ignored", int'(offerValid), 0);
    raise(8'h61, 1'b0, 1);
    step();
    checkEq("R7 lowest accepted", int'(offerVector), 8'h61);
    doAck();
    doEoi();

    // R5: nested retirement and empty eoi
    raise(8'h30);
    step();
    doAck();
    raise(8'h80);
    step();
    checkEq("R2 nested offer", int'(offerVector), 8'h80);
    doAck();
    checkEq("R5 nested ppr", int'(pprOut), 8'h80);
    doEoi();
    checkEq("R5 highest retired", int'(pprOut), 8'h30);
    doEoi();
    checkEq("R5 all retired", int'(pprOut), 0);
    writeTpr(8'h25);
    doEoi();
    checkEq("R5 empty eoi no pulse", int'(eoiBcast), 0);
    checkEq("R5 empty eoi ppr", int'(pprOut), 8'h25);
    writeTpr(0);

    // R8: timer coalescing, counter saturates at 3
    for (int k = 0; k < 5; k++) raise(8'h90);
    for (int k = 0; k < 4; k++) begin
      step();
      checkEq("R8 timer re-offer", int'(offerValid), 1);
      checkEq("R8 timer vector", int'(offerVector), 8'h90);
      doAck();
    end
    step();
    checkEq("R8 timer drained", int'(offerValid), 0);
    doEoi();
    checkEq("R8 isr retired", int'(pprOut), 0);

    // R9: disabled unit
    enable = 1'b0;
    raise(8'h70);
    enable = 1'b1;
    step();
    checkEq("R9 request ignored", int'(offerValid), 0);
    raise(8'h71);
    enable = 1'b0;
    step();
    checkEq("R9 no offer disabled", int'(offerValid), 0);
    enable = 1'b1;
    step();
    checkEq("R9 offer resumes", int'(offerVector), 8'h71);
    doAck();
    doEoi();

    // R3: reserved vector substitution
    checkEq("R3 err clear before", int'(errStatus), 0);
    raise(5);
    step();
    checkEq("R3 substituted valid", int'(offerValid), 1);
    checkEq("R3 substituted vector", int'(offerVector), 8'hFE);
    checkEq("R3 error flag", int'(errStatus), 8'h20);
    doAck();
    checkEq("R3 error vector in service", int'(pprOut), 8'hF0);
    step();
    checkEq("R3 low vector masked", int'(offerValid), 0);
    checkEq("R3 flag sticky", int'(errStatus), 8'h20);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule